// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block is the bus-facing half of a 16-bit segmented processor core. It holds a code segment value and an instruction pointer, turns them into a 20-bit physical byte address, and reads instruction bytes ahead of need from a simple synchronous memory port. The fetched bytes go into a six-entry byte queue. An execution-side consumer drains that queue one byte per pop while the unit keeps fetching, so fetch and execute overlap.

A change of control flow is signalled with a flush pulse carrying a new segment and offset. The flush empties the queue, discards any read response that arrives in the same cycle, and starts fetching at the new address on the next cycle. A separate combinational address generator maps any data segment and offset pair to its 20-bit physical address with the same arithmetic.

The fetch controller is a three-state machine. `PF_FETCH` issues a read when a queue slot is free and goes to `PF_AWAIT`. It goes to `PF_STALL` if the queue is full, and it stays in `PF_FETCH` on a flush. `PF_AWAIT` waits for the read response and returns to `PF_FETCH` on `mem_rvalid` or on a flush. `PF_STALL` returns to `PF_FETCH` once a slot frees up or on a flush. Reset enters `PF_FETCH`.

Top module: `pfu_top`

## Requirements
- R1: `data_phys` equals (`data_seg` × 16 + `data_off`) modulo 2^20. It is combinational, so the carry out of bit 19 is dropped.
- R2: The address generator maps segment 4370h with offset 561Eh to 48D1Eh, and segment 7A32h with offset 0028h to 7A348h.
- R3: Every fetch address is (CS × 16 + IP) modulo 2^20. IP rises by one after each byte is written into the queue and wraps from FFFFh to 0000h. CS does not change between flushes.
- R4: While `q_empty` is 0, `q_byte` shows the oldest queued byte. A `pop` high at a clock edge removes exactly that byte. Bytes leave in the order of their fetch addresses.
- R5: The queue never holds more than six bytes.
- R6: `mem_req` is high only while fewer than six bytes are queued. Without pops, exactly six reads follow a flush and `mem_req` then stays low.
- R7: The memory answers a `mem_req` with `mem_rvalid` one cycle later, with the byte at `mem_addr`. `mem_req` is never high in two consecutive cycles, so at most one read is outstanding.
- R8: After a clock edge with `flush` high, `q_empty` is 1. A response arriving at that edge is dropped. In the next cycle `mem_req` is high with the address of `flush_seg`:`flush_off`.
- R9: A `pop` while `q_empty` is 1 is ignored: no byte is lost, including a byte written at the same edge.
- R10: In the first cycle after reset, `q_empty` is 1 and `mem_req` is high with address (RESET_CS × 16 + RESET_IP), by default FFFF0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Redirect fetch, clear queue |
| flush_seg | input | 16 | New code segment value |
| flush_off | input | 16 | New instruction pointer |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Physical read address |
| mem_rvalid | input | 1 | Read data valid, one cycle after request |
| mem_rdata | input | 8 | Read data byte |
| pop | input | 1 | Consumer takes the head byte |
| q_empty | output | 1 | Queue holds no byte |
| q_byte | output | 8 | Head byte of the queue |
| data_seg | input | 16 | Data access segment |
| data_off | input | 16 | Data access offset |
| data_phys | output | 20 | Data access physical address |

## Verification
The bench sweeps a grid of segment and offset pairs that includes FFFFh on both sides, and checks each result against plain integer arithmetic. A design that keeps the carry out of bit 19, or shifts by the wrong amount, miscompares there. It streams bytes from start points where IP crosses FFFFh, where the physical sum crosses 2^20, and from the reset address. A unit that carries the IP wrap into CS, or reorders bytes, returns the wrong byte at the crossing. It fills the queue with no pops and counts the memory requests: an off-by-one full test yields five or seven reads. It also places a flush exactly on the edge where a response returns and pops an empty queue as a byte lands. A design that keeps the stale byte, or lets the empty pop swallow the new byte, shows the wrong head byte.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
    typedef enum logic [1:0] {
        PF_FETCH = 2'd0,
        PF_AWAIT = 2'd1,
        PF_STALL = 2'd2
    } pf_state_e;
endpackage

// File: rtl/pfu_addr_gen.sv
module pfu_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    localparam int SHIFT = PA_W - SEG_W;
    localparam int OPAD  = PA_W - OFF_W;

    // Sum is formed at PA_W bits, so the carry out of the top bit is dropped.
    logic [PA_W-1:0] seg_base;
    logic [PA_W-1:0] off_ext;

    assign seg_base = {seg, {SHIFT{1'b0}}};
    assign off_ext  = {{OPAD{1'b0}}, off};
    assign phys     = seg_base + off_ext;
endmodule

// File: rtl/pfu_byte_queue.sv
module pfu_byte_queue #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [DATA_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (count_q == '0);
    assign full    = (count_q == CNT_W'(DEPTH));
    assign do_push = push && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else if (clear) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_push && (wr_ptr == PTR_W'(i))) slots[i] <= push_data;
        end
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> !full);

    a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clear) |=> (empty && $stable(rd_ptr)));

    a_r4_pop_moves_head: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !clear) |=> (rd_ptr != $past(rd_ptr)));
endmodule

// File: rtl/pfu_fetch_ctrl.sv
module pfu_fetch_ctrl
    import pfu_pkg::*;
#(
    parameter int          SEG_W    = 16,
    parameter logic [15:0] RESET_CS = 16'hFFFF,
    parameter logic [15:0] RESET_IP = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SEG_W-1:0] flush_seg,
    input  logic [SEG_W-1:0] flush_off,
    input  logic             q_full,
    input  logic             mem_rvalid,
    output logic             mem_req,
    output logic             push,
    output logic             clear,
    output logic [SEG_W-1:0] cs,
    output logic [SEG_W-1:0] ip
);
    pf_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PF_FETCH;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PF_FETCH: begin
                if (flush)       state_nx = PF_FETCH;
                else if (q_full) state_nx = PF_STALL;
                else             state_nx = PF_AWAIT;
            end
            PF_AWAIT: begin
                if (flush || mem_rvalid) state_nx = PF_FETCH;
                else                     state_nx = PF_AWAIT;
            end
            PF_STALL: begin
                if (flush || !q_full) state_nx = PF_FETCH;
                else                  state_nx = PF_STALL;
            end
            default: state_nx = PF_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = 1'b0;
        push    = 1'b0;
        clear   = flush;
        unique case (state_q)
            PF_FETCH: mem_req = !q_full && !flush;
            PF_AWAIT: push    = mem_rvalid && !flush;
            PF_STALL: ;
            default:  ;
        endcase
    end

    // code segment and instruction pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs <= SEG_W'(RESET_CS);
            ip <= SEG_W'(RESET_IP);
        end else if (flush) begin
            cs <= flush_seg;
            ip <= flush_off;
        end else if (push) begin
            ip <= ip + SEG_W'(1);
        end
    end

    a_r3_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> ((ip == $past(ip) + SEG_W'(1)) && $stable(cs)));

    a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r6_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !mem_req);

    a_r8_flush_loads: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((cs == $past(flush_seg)) && (ip == $past(flush_off))));
endmodule

// File: rtl/pfu_top.sv
module pfu_top #(
    parameter int          DEPTH    = 6,
    parameter int          DATA_W   = 8,
    parameter int          SEG_W    = 16,
    parameter int          PA_W     = 20,
    parameter logic [15:0] RESET_CS = 16'hFFFF,
    parameter logic [15:0] RESET_IP = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SEG_W-1:0]  flush_seg,
    input  logic [SEG_W-1:0]  flush_off,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              pop,
    output logic              q_empty,
    output logic [DATA_W-1:0] q_byte,
    input  logic [SEG_W-1:0]  data_seg,
    input  logic [SEG_W-1:0]  data_off,
    output logic [PA_W-1:0]   data_phys
);
    logic             q_full, q_push, q_clear;
    logic [SEG_W-1:0] cs, ip;

    pfu_fetch_ctrl #(
        .SEG_W    (SEG_W),
        .RESET_CS (RESET_CS),
        .RESET_IP (RESET_IP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_seg  (flush_seg),
        .flush_off  (flush_off),
        .q_full     (q_full),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .push       (q_push),
        .clear      (q_clear),
        .cs         (cs),
        .ip         (ip)
    );

    pfu_byte_queue #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q_clear),
        .push      (q_push),
        .push_data (mem_rdata),
        .pop       (pop),
        .empty     (q_empty),
        .full      (q_full),
        .head      (q_byte)
    );

    pfu_addr_gen #(.SEG_W(SEG_W), .OFF_W(SEG_W), .PA_W(PA_W)) u_fetch_ag (
        .seg  (cs),
        .off  (ip),
        .phys (mem_addr)
    );

    pfu_addr_gen #(.SEG_W(SEG_W), .OFF_W(SEG_W), .PA_W(PA_W)) u_data_ag (
        .seg  (data_seg),
        .off  (data_off),
        .phys (data_phys)
    );

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> q_empty);

    a_r3_addr_held_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !flush) |=> $stable(mem_addr));
endmodule

// File: tb/tb_pfu_top.sv
module tb_pfu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_seg = '0, flush_off = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        pop = 1'b0;
    logic        q_empty;
    logic [7:0]  q_byte;
    logic [15:0] data_seg = '0, data_off = '0;
    logic [19:0] data_phys;

    int n_vec = 0, n_bad = 0, req_cnt = 0, dbl_req = 0;
    bit req_prev = 1'b0, finished = 1'b0;

    pfu_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
        .flush_off(flush_off), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pop(pop),
        .q_empty(q_empty), .q_byte(q_byte), .data_seg(data_seg),
        .data_off(data_off), .data_phys(data_phys)
    );

    always #5ns clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] ref_phys(input logic [15:0] s, input logic [15:0] o);
        int unsigned t;
        t = (int'(s) * 16 + int'(o)) % 1048576;
        return t[19:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory model: one-cycle read latency
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n) begin
                if (mem_req) req_cnt++;
                if (mem_req && req_prev) dbl_req++;
                req_prev = mem_req;
            end
            mem_rvalid <= mem_req && rst_n;
            mem_rdata  <= mem_byte(mem_addr);
        end
    end

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        flush = 1'b1; flush_seg = s; flush_off = o; pop = 1'b0;
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk(q_empty == 1'b1, "R8 empty after flush", 32'(q_empty), 32'd1);
        chk(mem_req == 1'b1, "R8 restart request", 32'(mem_req), 32'd1);
        chk(mem_addr == ref_phys(s, o), "R8 restart address", 32'(mem_addr), 32'(ref_phys(s, o)));
    endtask

    // pops n bytes, each compared with the byte at its expected address (R3, R4)
    task automatic drain(input logic [15:0] s, input logic [15:0] o, input int first, input int n);
        int k = first;
        int guard = 0;
        while (k < first + n && guard < 2000) begin
            if (!q_empty) begin
                logic [19:0] a;
                a = ref_phys(s, 16'(int'(o) + k));
                chk(q_byte == mem_byte(a), "R3/R4 stream byte", 32'(q_byte), 32'(mem_byte(a)));
                pop = 1'b1;
                k++;
            end else begin
                pop = 1'b0;
            end
            @(negedge clk);
            pop = 1'b0;
            #1;
            guard++;
        end
        chk(k == first + n, "R4 stream progress", 32'(k), 32'(first + n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state and first fetch
        chk(q_empty == 1'b1, "R10 empty after reset", 32'(q_empty), 32'd1);
        chk(mem_req == 1'b1, "R10 first request", 32'(mem_req), 32'd1);
        chk(mem_addr == 20'hFFFF0, "R10 reset address", 32'(mem_addr), 32'hFFFF0);
        drain(16'hFFFF, 16'h0000, 0, 10);

        // R2: fixed examples
        data_seg = 16'h4370; data_off = 16'h561E; #1;
        chk(data_phys == 20'h48D1E, "R2 example one", 32'(data_phys), 32'h48D1E);
        data_seg = 16'h7A32; data_off = 16'h0028; #1;
        chk(data_phys == 20'h7A348, "R2 example two", 32'(data_phys), 32'h7A348);

        // R1: sweep, edge values included
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                data_seg = (i == 63) ? 16'hFFFF : 16'(i * 1031);
                data_off = (j == 63) ? 16'hFFFF : 16'(j * 1029);
                #1;
                chk(data_phys == ref_phys(data_seg, data_off), "R1 address sum",
                    32'(data_phys), 32'(ref_phys(data_seg, data_off)));
            end
        end

        // R3/R4: streams across IP wrap and 20-bit wrap
        do_flush(16'h4370, 16'h561E);  drain(16'h4370, 16'h561E, 0, 30);
        do_flush(16'h7A32, 16'h0028);  drain(16'h7A32, 16'h0028, 0, 30);
        do_flush(16'hF000, 16'hFFFC);  drain(16'hF000, 16'hFFFC, 0, 30);
        do_flush(16'hFFFF, 16'hFFF8);  drain(16'hFFFF, 16'hFFF8, 0, 30);

        // R5/R6: fill with no pops, count reads
        do_flush(16'h1234, 16'h0100);
        base = req_cnt;
        repeat (30) @(negedge clk);
        #1;
        chk(req_cnt - base == 6, "R6 reads to fill", 32'(req_cnt - base), 32'd6);
        chk(mem_req == 1'b0, "R6 idle when full", 32'(mem_req), 32'd0);
        chk(q_empty == 1'b0, "R5 queue holds bytes", 32'(q_empty), 32'd0);
        drain(16'h1234, 16'h0100, 0, 20);

        // R9: pop on empty queue, including on the edge that writes a byte
        do_flush(16'h2000, 16'h0040);
        pop = 1'b1;
        @(negedge clk); #1;
        chk(q_empty == 1'b1, "R9 still empty", 32'(q_empty), 32'd1);
        @(negedge clk); pop = 1'b0; #1;
        chk(q_empty == 1'b0, "R9 byte kept", 32'(q_empty), 32'd0);
        chk(q_byte == mem_byte(ref_phys(16'h2000, 16'h0040)), "R9 head byte",
            32'(q_byte), 32'(mem_byte(ref_phys(16'h2000, 16'h0040))));
        drain(16'h2000, 16'h0040, 0, 12);

        // R8: flush on the edge where a response returns
        do_flush(16'h3000, 16'h0000);
        do_flush(16'h5555, 16'hAAAA);
        drain(16'h5555, 16'hAAAA, 0, 12);

        // R7: no back-to-back requests over the whole run
        chk(dbl_req == 0, "R7 one outstanding read", 32'(dbl_req), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule